// File: doc/BRIEF.md
# Load Result Extract and Extend Unit

This block produces the register writeback of a load instruction in a multicycle processor core. A sequencer outside the block reports the current stage on a small code: idle, instruction fetch, execute or load wait. In the execute stage of a load, the block records three things: where inside a 32-bit word the load address falls, the destination register index and the width/sign selector of the instruction. The address offset is the two low bits of the base register value plus the sign-extended 12-bit immediate. During instruction fetch the same offset register takes the low bits of the program counter instead.

In the load-wait stage the block takes the word returned by memory. It picks the addressed byte, halfword or the whole word and extends it with sign bits or zeros. The resulting writeback (register index and value) is registered and shown for one cycle. A load that would need bytes from two words is reported on an error output instead of being written. A selector code that names no load becomes a harmless write of zero to register 0.

Top module: `ldx_unit`

## Requirements
- R1: While reset (synchronous, active high) is asserted and in the cycle after it is released, `wb_valid_o` and `wb_err_o` are 0 and `wb_rd_o` and `wb_data_o` are 0.
- R2: In a cycle with `stage_i` = 1 (fetch), the stored byte offset becomes `pc_i[1:0]`. A following load-wait uses that offset with the register index and selector captured earlier.
- R3: In a cycle with `stage_i` = 2 (execute) and `instr_i[6:0]` = 7'h03, the block stores the byte offset as bits [1:0] of `base_i` plus the sign-extended `instr_i[31:20]`. It also stores the register index `instr_i[11:7]` and the selector `instr_i[14:12]`.
- R4: In an execute cycle whose `instr_i[6:0]` is not 7'h03, and in idle or load-wait cycles, the stored offset, register index and selector keep their values.
- R5: Selector 0 (signed byte) and selector 4 (unsigned byte) write the byte at bits [8*off+7 : 8*off] of the memory word. Selector 0 extends it with copies of its bit 7; selector 4 extends it with zeros.
- R6: Selector 1 (signed half) and selector 5 (unsigned half) at offset 0, 1 or 2 write the 16 bits that start at bit 8*off. Selector 1 extends them from their bit 15; selector 5 extends them with zeros.
- R7: Selector 2 (word) at offset 0 writes the whole memory word unchanged.
- R8: A half load at offset 3, or a word load at a nonzero offset, raises `wb_err_o` for one cycle with `wb_valid_o` low and no write.
- R9: Selectors 3, 6 and 7 produce a valid write with register index 0 and value 0.
- R10: The stage codes are 0 idle, 1 fetch, 2 execute, 3 load wait. The result of each load-wait cycle appears on the outputs in the next cycle only, and only for that one cycle.
- R11: `wb_valid_o` and `wb_err_o` are never both high, and whenever `wb_valid_o` is low, `wb_rd_o` and `wb_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stage_i | input | 2 | Sequencer stage: 0 idle, 1 fetch, 2 execute, 3 load wait |
| pc_i | input | 32 | Program counter |
| instr_i | input | 32 | Current instruction word |
| base_i | input | 32 | Base register value of the instruction |
| mem_word_i | input | 32 | Word returned by memory, sampled in load wait |
| wb_valid_o | output | 1 | Register write request, one cycle |
| wb_err_o | output | 1 | Load crossed a word boundary, one cycle |
| wb_rd_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Extended load value |

## Verification
The offset, register index and selector are stored at the clock edge that ends the fetch or execute cycle. The writeback is stored at the edge that ends the load-wait cycle, so its result appears one cycle after the load-wait stage is driven. The bench drives every input at the falling edge. It reads the outputs at the falling edge right after the load-wait edge, and it checks that they are back at zero one cycle later. The sweep covers all eight selectors, all four offsets, several memory words and immediates of both signs. Each expected value is built in the bench by shifting and masking the word.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

    localparam int XLEN     = 32;
    localparam int RIDX_W   = 5;
    localparam int LANES    = XLEN / 8;
    localparam int OFF_W    = $clog2(LANES);
    localparam int IMM_W    = 12;
    localparam int SEL_W    = 3;

    localparam logic [6:0] OPC_LOAD = 7'b0000011;

    localparam logic [SEL_W-1:0] SEL_BYTE_S = 3'd0;
    localparam logic [SEL_W-1:0] SEL_HALF_S = 3'd1;
    localparam logic [SEL_W-1:0] SEL_WORD   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_BYTE_U = 3'd4;
    localparam logic [SEL_W-1:0] SEL_HALF_U = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_EXEC   = 2'd2,
        ST_LDWAIT = 2'd3
    } stage_e;

    typedef struct packed {
        logic [RIDX_W-1:0] rd;
        logic [SEL_W-1:0]  sel;
        logic [OFF_W-1:0]  off;
    } ld_ctx_t;

    typedef struct packed {
        logic [XLEN-1:0] value;
        logic            misaligned;
        logic            unknown;
    } lane_res_t;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [RIDX_W-1:0] rd;
        logic [XLEN-1:0]   data;
    } wb_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] imm);
        return {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    endfunction

    function automatic logic [XLEN-1:0] ext8(input logic [7:0] b, input logic signed_ext);
        return {{(XLEN-8){signed_ext & b[7]}}, b};
    endfunction

    function automatic logic [XLEN-1:0] ext16(input logic [15:0] h, input logic signed_ext);
        return {{(XLEN-16){signed_ext & h[15]}}, h};
    endfunction

endpackage

// File: rtl/ldx_ctx_latch.sv
module ldx_ctx_latch
    import ldx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  stage_e          stage,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] base,
    output ld_ctx_t         ctx_o
);

    ld_ctx_t         ctx_q;
    logic [XLEN-1:0] ld_addr;
    logic            is_load;
    logic            unused_bits;

    assign is_load     = (instr[6:0] == OPC_LOAD);
    assign ld_addr     = base + sext_imm(instr[31:20]);
    assign unused_bits = ^{ld_addr[XLEN-1:OFF_W], pc[XLEN-1:OFF_W], instr[19:15]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else begin
            case (stage)
                ST_FETCH: ctx_q.off <= pc[OFF_W-1:0];
                ST_EXEC: begin
                    if (is_load) begin
                        ctx_q.off <= ld_addr[OFF_W-1:0];
                        ctx_q.rd  <= instr[11:7];
                        ctx_q.sel <= instr[14:12];
                    end
                end
                default: ctx_q <= ctx_q;
            endcase
        end
    end

    assign ctx_o = ctx_q;

    // R2: fetch loads the offset from the program counter
    assert_fetch_off_R2: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_FETCH) |=> (ctx_o.off == $past(pc[OFF_W-1:0])));

    // R4: a non-load execute cycle leaves the context alone
    assert_nonload_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_EXEC && instr[6:0] != OPC_LOAD) |=> $stable(ctx_o));

    // R4: idle and load-wait cycles leave the context alone
    assert_quiet_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_IDLE || stage == ST_LDWAIT) |=> $stable(ctx_o));

    // R3: a load in execute records its register index
    assert_rd_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_EXEC && instr[6:0] == OPC_LOAD) |=> (ctx_o.rd == $past(instr[11:7])));

endmodule

// File: rtl/ldx_lane_select.sv
module ldx_lane_select
    import ldx_pkg::*;
(
    input  logic [XLEN-1:0]  word,
    input  logic [OFF_W-1:0] off,
    input  logic [SEL_W-1:0] sel,
    output lane_res_t        res_o
);

    logic [7:0]  byte_lane [LANES];
    logic [15:0] half_lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign byte_lane[g] = word[8*g +: 8];
        if (g < LANES - 1) begin : g_half
            assign half_lane[g] = word[8*g +: 16];
        end else begin : g_half_edge
            assign half_lane[g] = {8'h00, word[8*g +: 8]};
        end
    end

    always_comb begin
        res_o = '0;
        case (sel)
            SEL_BYTE_S: res_o.value = ext8(byte_lane[off], 1'b1);
            SEL_BYTE_U: res_o.value = ext8(byte_lane[off], 1'b0);
            SEL_HALF_S, SEL_HALF_U: begin
                if (off == OFF_W'(LANES - 1)) begin
                    res_o.misaligned = 1'b1;
                end else begin
                    res_o.value = ext16(half_lane[off], sel == SEL_HALF_S);
                end
            end
            SEL_WORD: begin
                if (off != '0) begin
                    res_o.misaligned = 1'b1;
                end else begin
                    res_o.value = word;
                end
            end
            default: res_o.unknown = 1'b1;
        endcase
    end

endmodule

// File: rtl/ldx_unit.sv
module ldx_unit
    import ldx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        stage_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [XLEN-1:0]   instr_i,
    input  logic [XLEN-1:0]   base_i,
    input  logic [XLEN-1:0]   mem_word_i,
    output logic              wb_valid_o,
    output logic              wb_err_o,
    output logic [RIDX_W-1:0] wb_rd_o,
    output logic [XLEN-1:0]   wb_data_o
);

    stage_e    stage;
    ld_ctx_t   ctx;
    lane_res_t lane;
    wb_t       wb_next;
    wb_t       wb_q;

    assign stage = stage_e'(stage_i);

    ldx_ctx_latch u_ctx (
        .clk   (clk),
        .rst   (rst),
        .stage (stage),
        .pc    (pc_i),
        .instr (instr_i),
        .base  (base_i),
        .ctx_o (ctx)
    );

    ldx_lane_select u_lane (
        .word  (mem_word_i),
        .off   (ctx.off),
        .sel   (ctx.sel),
        .res_o (lane)
    );

    always_comb begin
        wb_next = '0;
        if (stage == ST_LDWAIT) begin
            if (lane.misaligned) begin
                wb_next.err = 1'b1;
            end else if (lane.unknown) begin
                wb_next.valid = 1'b1;
            end else begin
                wb_next.valid = 1'b1;
                wb_next.rd    = ctx.rd;
                wb_next.data  = lane.value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_next;
        end
    end

    assign wb_valid_o = wb_q.valid;
    assign wb_err_o   = wb_q.err;
    assign wb_rd_o    = wb_q.rd;
    assign wb_data_o  = wb_q.data;

    // R10: any result follows a load-wait cycle
    assert_after_wait_R10: assert property (@(posedge clk) disable iff (rst)
        (wb_valid_o || wb_err_o) |-> ($past(stage_i) == 2'd3));

    // R11: write and error never together
    assert_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(wb_valid_o && wb_err_o));

    // R11: quiet outputs when no write
    assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !wb_valid_o |-> (wb_rd_o == '0 && wb_data_o == '0));

    // R5: unsigned byte leaves the upper bits clear
    assert_byte_zext_R5: assert property (@(posedge clk) disable iff (rst)
        (wb_valid_o && $past(ctx.sel) == SEL_BYTE_U) |-> (wb_data_o[XLEN-1:8] == '0));

    // R8: an error only comes from a half or word selector
    assert_err_sel_R8: assert property (@(posedge clk) disable iff (rst)
        wb_err_o |-> ($past(ctx.sel) == SEL_HALF_S || $past(ctx.sel) == SEL_HALF_U
                      || $past(ctx.sel) == SEL_WORD));

endmodule

// File: tb/test_ldx_unit.sv
module test_ldx_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  stage_i = 2'd0;
    logic [31:0] pc_i = '0;
    logic [31:0] instr_i = '0;
    logic [31:0] base_i = '0;
    logic [31:0] mem_word_i = '0;
    logic        wb_valid_o;
    logic        wb_err_o;
    logic [4:0]  wb_rd_o;
    logic [31:0] wb_data_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    ldx_unit i_ldx_unit (
        .clk        (clk),
        .rst        (rst),
        .stage_i    (stage_i),
        .pc_i       (pc_i),
        .instr_i    (instr_i),
        .base_i     (base_i),
        .mem_word_i (mem_word_i),
        .wb_valid_o (wb_valid_o),
        .wb_err_o   (wb_err_o),
        .wb_rd_o    (wb_rd_o),
        .wb_data_o  (wb_data_o)
    );

    task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [2:0] sel, input logic [1:0] off, input logic [31:0] word,
                                  input logic [4:0] rd, output logic ev, output logic ee,
                                  output logic [4:0] erd, output logic [31:0] ed);
        logic [31:0] sh;
        sh = word >> (8 * off);
        ev = 1'b1; ee = 1'b0; erd = rd; ed = '0;
        case (sel)
            3'd0: ed = {{24{sh[7]}}, sh[7:0]};
            3'd4: ed = {24'h0, sh[7:0]};
            3'd1: if (off == 2'd3) begin ev = 0; ee = 1; end else ed = {{16{sh[15]}}, sh[15:0]};
            3'd5: if (off == 2'd3) begin ev = 0; ee = 1; end else ed = {16'h0, sh[15:0]};
            3'd2: if (off != 2'd0) begin ev = 0; ee = 1; end else ed = word;
            default: erd = 5'd0;
        endcase
        if (!ev) erd = 5'd0;
    endfunction

    function automatic string tag_of(input logic [2:0] sel, input logic [1:0] off);
        case (sel)
            3'd0, 3'd4: return "R5";
            3'd1, 3'd5: return (off == 2'd3) ? "R8" : "R6";
            3'd2: return (off != 2'd0) ? "R8" : "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input logic [2:0] sel, input logic [1:0] off, input logic [31:0] word,
                           input logic [4:0] rd, input string tag);
        logic ev, ee;
        logic [4:0] erd;
        logic [31:0] ed;
        model(sel, off, word, rd, ev, ee, erd, ed);
        check(wb_valid_o == ev && wb_err_o == ee && wb_rd_o == erd && wb_data_o == ed, tag,
              {wb_valid_o, wb_err_o, 1'b0, wb_rd_o, wb_data_o}, {ev, ee, 1'b0, erd, ed});
    endtask

    // execute stage then load wait; outputs read one edge after load wait
    task automatic run_load(input logic [2:0] sel, input logic [4:0] rd, input logic [31:0] base,
                            input logic [11:0] imm, input logic [31:0] word, input logic [6:0] opc);
        @(negedge clk);
        stage_i = 2'd2;
        instr_i = {imm, 5'd3, sel, rd, opc};
        base_i  = base;
        @(negedge clk);
        stage_i    = 2'd3;
        mem_word_i = word;
        @(negedge clk);
        stage_i = 2'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] words [3];
        logic [11:0] imms [3];
        words[0] = 32'h8F7E_6D5C;
        words[1] = 32'h1234_F0A5;
        words[2] = 32'h7F80_01FF;
        imms[0]  = 12'h000;
        imms[1]  = 12'hFFD;
        imms[2]  = 12'h7FF;

        repeat (3) @(negedge clk);
        check(wb_valid_o == 0 && wb_err_o == 0 && wb_rd_o == 0 && wb_data_o == 0, "R1 in reset",
              {wb_valid_o, wb_err_o, 1'b0, wb_rd_o, wb_data_o}, '0);
        rst = 1'b0;
        @(negedge clk);
        check(wb_valid_o == 0 && wb_err_o == 0 && wb_rd_o == 0 && wb_data_o == 0, "R1 after reset",
              {wb_valid_o, wb_err_o, 1'b0, wb_rd_o, wb_data_o}, '0);

        // R3 sweep of selectors, offsets, words and immediates (R5..R9)
        for (int s = 0; s < 8; s++) begin
            for (int o = 0; o < 4; o++) begin
                for (int w = 0; w < 3; w++) begin
                    logic [31:0] sx, base, addr;
                    logic [4:0] rd;
                    sx   = {{20{imms[w][11]}}, imms[w]};
                    base = 32'h2000_0000 + 32'(o) - sx + 32'(w * 64);
                    addr = base + sx;
                    rd   = 5'((s * 4 + o + w) % 31 + 1);
                    run_load(3'(s), rd, base, imms[w], words[w], 7'h03);
                    compare(3'(s), addr[1:0], words[w], rd, tag_of(3'(s), addr[1:0]));
                end
            end
        end

        // R10: outputs drop one cycle later
        run_load(3'd4, 5'd12, 32'h100, 12'h001, 32'hAABBCCDD, 7'h03);
        compare(3'd4, 2'd1, 32'hAABBCCDD, 5'd12, "R10 pulse");
        @(negedge clk);
        check(wb_valid_o == 0 && wb_err_o == 0, "R10 one cycle",
              {38'h0, wb_valid_o, wb_err_o}, '0);

        // R8: error also lasts one cycle
        run_load(3'd2, 5'd6, 32'h102, 12'h000, 32'h1111_2222, 7'h03);
        compare(3'd2, 2'd2, 32'h1111_2222, 5'd6, "R8 word err");
        @(negedge clk);
        check(wb_err_o == 0, "R8 err one cycle", {39'h0, wb_err_o}, '0);

        // R4: a non-load execute keeps the stored context
        @(negedge clk);
        stage_i = 2'd2; instr_i = {12'h000, 5'd3, 3'd0, 5'd9, 7'h03}; base_i = 32'h201;
        @(negedge clk);
        stage_i = 2'd2; instr_i = {12'h002, 5'd3, 3'd2, 5'd20, 7'h13}; base_i = 32'h301;
        @(negedge clk);
        stage_i = 2'd3; mem_word_i = 32'hC3B2_A190;
        @(negedge clk);
        stage_i = 2'd0;
        compare(3'd0, 2'd1, 32'hC3B2_A190, 5'd9, "R4 nonload hold");

        // R4: idle cycles keep the context, repeated load wait reuses it
        repeat (3) @(negedge clk);
        stage_i = 2'd3; mem_word_i = 32'h0000_8000;
        @(negedge clk);
        stage_i = 2'd0;
        compare(3'd0, 2'd1, 32'h0000_8000, 5'd9, "R4 idle hold");

        // R2: fetch replaces the offset only
        @(negedge clk);
        stage_i = 2'd2; instr_i = {12'h000, 5'd3, 3'd4, 5'd7, 7'h03}; base_i = 32'h400;
        @(negedge clk);
        stage_i = 2'd1; pc_i = 32'h0000_0076;
        @(negedge clk);
        stage_i = 2'd3; mem_word_i = 32'h44F3_2211;
        @(negedge clk);
        stage_i = 2'd0;
        compare(3'd4, 2'd2, 32'h44F3_2211, 5'd7, "R2 fetch offset");

        @(negedge clk);
        stage_i = 2'd1; pc_i = 32'h0000_0083;
        @(negedge clk);
        stage_i = 2'd3; mem_word_i = 32'h9A00_0000;
        @(negedge clk);
        stage_i = 2'd0;
        compare(3'd4, 2'd3, 32'h9A00_0000, 5'd7, "R2 fetch offset 3");

        // R11: quiet outputs while idle
        @(negedge clk);
        check(wb_valid_o == 0 && wb_rd_o == 0 && wb_data_o == 0, "R11 idle quiet",
              {wb_valid_o, wb_err_o, 1'b0, wb_rd_o, wb_data_o}, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule